// File: doc/BRIEF.md
# Prioritised External Interrupt Router

This block collects level-sensitive interrupt requests from a parameterised set of sources and steers them to a set of hart contexts. A context is one privilege level on one hart. Each context output drives that hart's external-interrupt pending input for its privilege level. Every source has one programmable priority. Every context has its own per-source enable mask and its own priority threshold. A context output is high whenever at least one request is eligible for it.

Software talks to the block over a simple synchronous register bus with single-cycle accesses and registered read data. It reads a per-context claim register to take ownership of the best pending source. When the handler is finished, it writes that source's number back to the same address. A source that has been claimed is locked out until it is completed. This lockout stops a level request that is still asserted from being taken a second time while its handler is running.

Top module: `irq_router`

## Requirements
- R1: After reset, every priority, enable, threshold, pending and in-service bit is zero. Every context output is low, and a claim read returns 0.
- R2: The priority of source i (1 ≤ i ≤ N_SRC) is read/write at byte address 4·i. Only the low PRIO_W bits are stored. Address 0 reads 0, because source 0 does not exist.
- R3: A source is eligible for a context only when all three hold: it is pending, its enable bit for that context is 1, and its priority is strictly greater than that context's threshold. As a result, priority 0 never interrupts and source 0 is never pending.
- R4: `ctx_irq[c]` is high exactly when some source is eligible for context c. It reflects a newly captured request right after the clock edge that captured it.
- R5: A read of the claim register of context c (address 0x200000 + 0x1000·c + 4) returns, on `bus_rdata` in the following cycle, the eligible source with the highest priority. Ties go to the lowest ID. The read returns 0 when no source is eligible.
- R6: A claim read clears the returned source's pending bit and marks that source in service. While it is in service it does not become pending again, even if its request stays high.
- R7: Writing a claimed ID to any context's claim address takes the source out of service. If its request is still high, the source is pending again one clock edge later.
- R8: A completion write whose ID is 0, is out of range, or is not currently in service changes nothing.
- R9: Pending bits are read-only at 0x1000 + 4·w, where bit b of word w is source 32·w + b. Writes to these addresses are ignored.
- R10: The enable word w of context c sits at 0x2000 + 0x80·c + 4·w, with the same bit packing as R9. Bit 0 always reads 0. The threshold of context c sits at 0x200000 + 0x1000·c and holds PRIO_W bits.
- R11: Enables and thresholds are separate for each context, so the same source can be eligible for one context and not for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | N_SRC | Level requests; bit i is source i (indices N_SRC:1) |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| ctx_irq | output | N_CTX | Per-context external interrupt request |

## Verification
A corrupted pending or in-service bit shows up at the ports within one access. Either `ctx_irq` is wrong right after the next clock edge, or the next claim read or pending-word read returns the wrong ID or mask. An arbitration fault is visible only through the claim value, so the bench uses ties, equal-to-threshold priorities and zero priorities to make a wrong comparison change the returned ID. A lost lockout appears as a second claim of the same ID while its request is still high.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   // Source identifiers carried on claim/complete are always 10 bits wide.
   localparam int ID_W         = 10;
   localparam int MAX_SRC      = 1023;
   localparam int MAX_CTX      = 15871;
   // Region bases and strides (byte addresses).
   localparam int PEND_BASE    = 32'h0000_1000;
   localparam int EN_BASE      = 32'h0000_2000;
   localparam int EN_STRIDE    = 32'h0000_0080;
   localparam int CTX_BASE     = 32'h0020_0000;
   localparam int CTX_STRIDE   = 32'h0000_1000;
   localparam int CLAIM_OFS    = 4;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway
   import irq_router_pkg::*;
#(
   parameter int N_SRC = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC:1]   src,
   input  logic             claim_vld,
   input  logic [ID_W-1:0]  claim_id,
   input  logic             cmpl_vld,
   input  logic [ID_W-1:0]  cmpl_id,
   output logic [N_SRC:0]   pend,
   output logic [N_SRC:0]   insvc
);
   assign pend[0]  = 1'b0;
   assign insvc[0] = 1'b0;

   for (genvar i = 1; i <= N_SRC; i++) begin : g_src
      logic take, done;
      assign take = claim_vld && (claim_id == ID_W'(i));
      assign done = cmpl_vld && (cmpl_id == ID_W'(i)) && insvc[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[i]  <= 1'b0;
            insvc[i] <= 1'b0;
         end else begin
            if (take) begin
               pend[i]  <= 1'b0;
               insvc[i] <= 1'b1;
            end else if (src[i] && !pend[i] && !insvc[i]) begin
               pend[i]  <= 1'b1;
            end
            if (done) begin
               insvc[i] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_router_pkg::*;
#(
   parameter int N_SRC  = 31,
   parameter int PRIO_W = 3
) (
   input  logic [N_SRC:1]             pend,
   input  logic [N_SRC:1]             en,
   input  logic [N_SRC:1][PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0]          thr,
   output logic [ID_W-1:0]            best_id,
   output logic                       irq
);
   logic [PRIO_W-1:0] best_p;

   // Ascending scan with strict compare: the first ID at a level wins ties,
   // and starting from the threshold enforces "strictly above threshold".
   always_comb begin
      best_p  = thr;
      best_id = '0;
      for (int i = 1; i <= N_SRC; i++) begin
         if (pend[i] && en[i] && (prio[i] > best_p)) begin
            best_p  = prio[i];
            best_id = ID_W'(i);
         end
      end
   end

   assign irq = (best_id != '0);
endmodule

// File: rtl/irq_router.sv
module irq_router
   import irq_router_pkg::*;
#(
   parameter int N_SRC  = 31,
   parameter int N_CTX  = 2,
   parameter int PRIO_W = 3,
   parameter int ADDR_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC:1]    irq_src,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [N_CTX-1:0]  ctx_irq
);
   localparam int N_WORDS = (N_SRC + 1 + 31) / 32;
   localparam int EN_BITS = N_WORDS * 32;

   if (N_SRC < 1 || N_SRC > MAX_SRC) begin : g_bad_src
      $error("N_SRC out of range");
   end
   if (N_CTX < 1 || N_CTX > MAX_CTX) begin : g_bad_ctx
      $error("N_CTX out of range");
   end
   if (PRIO_W < 1 || PRIO_W > 32) begin : g_bad_prio
      $error("PRIO_W out of range");
   end
   if (ADDR_W < 26 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must be 26..32");
   end

   function automatic logic [EN_BITS-1:0] src_mask();
      logic [EN_BITS-1:0] m;
      for (int b = 0; b < EN_BITS; b++) m[b] = (b >= 1) && (b <= N_SRC);
      return m;
   endfunction
   localparam logic [EN_BITS-1:0] EN_MASK = src_mask();

   // Storage
   logic [N_SRC:1][PRIO_W-1:0]        prio_q;
   logic [N_CTX-1:0][EN_BITS-1:0]     en_q;
   logic [N_CTX-1:0][PRIO_W-1:0]      thr_q;
   logic [31:0]                       rdata_q;

   // Gateway / arbiter wiring
   logic [N_SRC:0]                    pend_w, insvc_w;
   logic [N_CTX-1:0][ID_W-1:0]        best_id;
   logic [EN_BITS-1:0]                pend_pad;

   // Decode
   logic [N_SRC:1]                    prio_hit;
   logic [N_CTX-1:0][N_WORDS-1:0]     en_hit;
   logic [N_CTX-1:0]                  thr_hit, clm_hit;
   logic [31:0]                       rd_mux;
   logic                              rd_stb, wr_stb;
   logic                              claim_vld, cmpl_vld;
   logic [ID_W-1:0]                   claim_id;

   assign rd_stb   = bus_sel && !bus_we;
   assign wr_stb   = bus_sel &&  bus_we;
   assign pend_pad = EN_BITS'(pend_w);

   always_comb begin
      prio_hit = '0;
      en_hit   = '0;
      thr_hit  = '0;
      clm_hit  = '0;
      rd_mux   = '0;
      claim_id = '0;
      for (int i = 1; i <= N_SRC; i++) begin
         if (bus_addr == ADDR_W'(4 * i)) begin
            prio_hit[i] = 1'b1;
            rd_mux      = 32'(prio_q[i]);
         end
      end
      for (int w = 0; w < N_WORDS; w++) begin
         if (bus_addr == ADDR_W'(PEND_BASE + 4 * w)) rd_mux = pend_pad[w*32 +: 32];
      end
      for (int c = 0; c < N_CTX; c++) begin
         for (int w = 0; w < N_WORDS; w++) begin
            if (bus_addr == ADDR_W'(EN_BASE + EN_STRIDE * c + 4 * w)) begin
               en_hit[c][w] = 1'b1;
               rd_mux       = en_q[c][w*32 +: 32];
            end
         end
         if (bus_addr == ADDR_W'(CTX_BASE + CTX_STRIDE * c)) begin
            thr_hit[c] = 1'b1;
            rd_mux     = 32'(thr_q[c]);
         end
         if (bus_addr == ADDR_W'(CTX_BASE + CTX_STRIDE * c + CLAIM_OFS)) begin
            clm_hit[c] = 1'b1;
            claim_id   = best_id[c];
            rd_mux     = 32'(best_id[c]);
         end
      end
   end

   assign claim_vld = rd_stb && (|clm_hit);
   assign cmpl_vld  = wr_stb && (|clm_hit);

   // Register storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q  <= '0;
         en_q    <= '0;
         thr_q   <= '0;
         rdata_q <= '0;
      end else begin
         if (rd_stb) rdata_q <= rd_mux;
         if (wr_stb) begin
            for (int i = 1; i <= N_SRC; i++) begin
               if (prio_hit[i]) prio_q[i] <= bus_wdata[PRIO_W-1:0];
            end
            for (int c = 0; c < N_CTX; c++) begin
               for (int w = 0; w < N_WORDS; w++) begin
                  if (en_hit[c][w]) en_q[c][w*32 +: 32] <= bus_wdata & EN_MASK[w*32 +: 32];
               end
               if (thr_hit[c]) thr_q[c] <= bus_wdata[PRIO_W-1:0];
            end
         end
      end
   end

   assign bus_rdata = rdata_q;

   irq_gateway #(.N_SRC(N_SRC)) i_gateway (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (irq_src),
      .claim_vld (claim_vld),
      .claim_id  (claim_id),
      .cmpl_vld  (cmpl_vld),
      .cmpl_id   (bus_wdata[ID_W-1:0]),
      .pend      (pend_w),
      .insvc     (insvc_w)
   );

   for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_arb (
         .pend    (pend_w[N_SRC:1]),
         .en      (en_q[c][N_SRC:1]),
         .prio    (prio_q),
         .thr     (thr_q[c]),
         .best_id (best_id[c]),
         .irq     (ctx_irq[c])
      );
   end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
   import irq_router_pkg::*;
#(
   parameter int N_SRC  = 31,
   parameter int N_CTX  = 2,
   parameter int ADDR_W = 26
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC:1]    irq_src,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [N_CTX-1:0]  ctx_irq,
   input logic [N_SRC:0]    pend,
   input logic [N_SRC:0]    insvc
);
   AST_ID0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pend[0] && !insvc[0]); // R3

   AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & insvc) == '0); // R6

   AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_irq != '0) |-> (pend != '0)); // R4

   for (genvar c = 0; c < N_CTX; c++) begin : g_c
      AST_CLAIM_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && !bus_we && !ctx_irq[c] &&
          bus_addr == ADDR_W'(CTX_BASE + CTX_STRIDE * c + CLAIM_OFS))
         |=> (bus_rdata == 32'd0)); // R5
   end

   for (genvar i = 1; i <= N_SRC; i++) begin : g_s
      AST_CLAIM_TAKES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(insvc[i]) |-> $past(pend[i])); // R6
      AST_PEND_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend[i]) |-> ($past(irq_src[i]) && !$past(insvc[i]))); // R7
   end
endmodule

bind irq_router irq_router_chk #(.N_SRC(N_SRC), .N_CTX(N_CTX), .ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_src   (irq_src),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .ctx_irq   (ctx_irq),
   .pend      (pend_w),
   .insvc     (insvc_w)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
   localparam int NS = 31;
   localparam int NC = 2;
   localparam int PW = 3;
   localparam int AW = 26;
   localparam int NW = (NS + 1 + 31) / 32;
   localparam int PEND_A = 32'h1000;
   localparam int EN_A   = 32'h2000;
   localparam int CTX_A  = 32'h200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NS:1] src = '0;
   logic sel = 1'b0, we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NC-1:0] irq;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_router #(.N_SRC(NS), .N_CTX(NC), .PRIO_W(PW), .ADDR_W(AW)) i_irq_router (
      .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_sel(sel), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .ctx_irq(irq)
   );

   // ---------------- reference model built from the requirements ----------
   int            m_prio [NS+1];
   logic [NS:0]   m_pend, m_insvc;
   logic [NW*32-1:0] m_en [NC];
   int            m_thr  [NC];
   logic [31:0]   m_rexp;

   function automatic int thr_addr(int c); return CTX_A + 32'h1000 * c; endfunction
   function automatic int clm_addr(int c); return CTX_A + 32'h1000 * c + 4; endfunction
   function automatic int en_addr(int c, int w); return EN_A + 32'h80 * c + 4 * w; endfunction

   function automatic int best(int c);  // R3, R5
      int bp = m_thr[c];
      int b = 0;
      for (int i = 1; i <= NS; i++)
         if (m_pend[i] && m_en[c][i] && m_prio[i] > bp) begin bp = m_prio[i]; b = i; end
      return b;
   endfunction

   function automatic logic [31:0] exp_read(int a);
      logic [NW*32-1:0] pp = (NW*32)'(m_pend);
      for (int i = 1; i <= NS; i++) if (a == 4 * i) return 32'(m_prio[i]);
      for (int w = 0; w < NW; w++) if (a == PEND_A + 4 * w) return pp[w*32 +: 32];
      for (int c = 0; c < NC; c++) begin
         for (int w = 0; w < NW; w++) if (a == en_addr(c, w)) return m_en[c][w*32 +: 32];
         if (a == thr_addr(c)) return 32'(m_thr[c]);
         if (a == clm_addr(c)) return 32'(best(c));
      end
      return 32'd0;
   endfunction

   always @(posedge clk) begin : model
      logic [NS:0] setm;
      int a, id;
      if (!rst_n) begin
         m_pend = '0; m_insvc = '0; m_rexp = '0;
         for (int i = 0; i <= NS; i++) m_prio[i] = 0;
         for (int c = 0; c < NC; c++) begin m_en[c] = '0; m_thr[c] = 0; end
      end else begin
         a = int'(addr);
         setm = '0;
         for (int i = 1; i <= NS; i++) setm[i] = src[i] && !m_pend[i] && !m_insvc[i];
         if (sel && !we) begin
            m_rexp = exp_read(a);
            for (int c = 0; c < NC; c++)
               if (a == clm_addr(c)) begin
                  id = best(c);
                  if (id != 0) begin m_pend[id] = 1'b0; m_insvc[id] = 1'b1; end
               end
         end
         if (sel && we) begin
            for (int i = 1; i <= NS; i++) if (a == 4 * i) m_prio[i] = int'(wdata[PW-1:0]);
            for (int c = 0; c < NC; c++) begin
               for (int w = 0; w < NW; w++)
                  if (a == en_addr(c, w)) begin
                     m_en[c][w*32 +: 32] = wdata;
                     if (w == 0) m_en[c][0] = 1'b0;
                     for (int b = 0; b < 32; b++) if (w*32 + b > NS) m_en[c][w*32 + b] = 1'b0;
                  end
               if (a == thr_addr(c)) m_thr[c] = int'(wdata[PW-1:0]);
               if (a == clm_addr(c)) begin
                  id = int'(wdata[9:0]);
                  if (id >= 1 && id <= NS && m_insvc[id]) m_insvc[id] = 1'b0;
               end
            end
         end
         m_pend = m_pend | setm;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_irq();
      logic [31:0] e = '0;
      for (int c = 0; c < NC; c++) e[c] = (best(c) != 0);
      chk("R4 ctx_irq", 32'(irq), e);
   endtask

   task automatic bus_wr(int a, logic [31:0] d);
      @(negedge clk); sel = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk); sel = 1'b0; we = 1'b0;
      chk_irq();
   endtask

   task automatic bus_rd(int a, string tag);
      @(negedge clk); sel = 1'b1; we = 1'b0; addr = AW'(a);
      @(negedge clk); sel = 1'b0;
      chk(tag, rdata, m_rexp);
      chk_irq();
   endtask

   task automatic set_src(int i, logic v);
      @(negedge clk); src[i] = v;
      @(negedge clk);
      chk_irq();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20250611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 irq reset", 32'(irq), 32'd0);
      bus_rd(clm_addr(0), "R1 claim at reset");
      bus_rd(PEND_A, "R1 pending at reset");
      bus_rd(4 * 3, "R1 priority at reset");
      // R2: priority registers
      bus_wr(4 * 3, 32'd5);
      bus_wr(4 * 5, 32'hFFFF_FFFD);
      bus_rd(4 * 3, "R2 prio readback");
      bus_rd(4 * 5, "R2 prio masked");
      bus_wr(0, 32'd7);
      bus_rd(0, "R2 offset zero reads 0");
      bus_wr(4 * 6, 32'd2);
      // R10: enable / threshold layout
      bus_wr(en_addr(0, 0), 32'hFFFF_FFFF);
      bus_rd(en_addr(0, 0), "R10 enable bit0 clear");
      bus_wr(en_addr(0, 0), (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 6) | (32'd1 << 7));
      bus_wr(thr_addr(0), 32'd2);
      bus_rd(thr_addr(0), "R10 threshold readback");
      // R3: threshold equality and priority zero never interrupt
      set_src(6, 1'b1);
      set_src(7, 1'b1);
      chk("R3 prio==thr and prio 0 idle", 32'(irq[0]), 32'd0);
      bus_rd(clm_addr(0), "R3 claim none eligible");
      // R5 tie: sources 3 and 5 both at 5
      bus_wr(4 * 5, 32'd5);
      set_src(5, 1'b1);
      set_src(3, 1'b1);
      bus_rd(PEND_A, "R9 pending word");
      bus_wr(PEND_A, 32'd0);
      bus_rd(PEND_A, "R9 pending write ignored");
      bus_rd(clm_addr(0), "R5 tie lowest id");
      bus_rd(clm_addr(0), "R5 second claim");
      // R6 lockout: both still requesting
      bus_rd(PEND_A, "R6 claimed not pending");
      bus_rd(clm_addr(0), "R6 claim after lockout");
      // R8: completion of non-claimed ids
      bus_wr(clm_addr(0), 32'd6);
      bus_wr(clm_addr(0), 32'd0);
      bus_wr(clm_addr(0), 32'd900);
      bus_rd(PEND_A, "R8 ignored completion");
      // R7: completion releases, level re-pends
      bus_wr(clm_addr(1), 32'd3);
      bus_rd(PEND_A, "R7 repend after complete");
      // R11: context independence
      bus_wr(en_addr(1, 0), 32'd1 << 3);
      bus_wr(thr_addr(1), 32'd0);
      bus_wr(thr_addr(0), 32'd6);
      chk("R11 ctx0 masked ctx1 live", 32'(irq), 32'b10);
      bus_rd(clm_addr(1), "R11 claim ctx1");
      bus_rd(clm_addr(0), "R11 claim ctx0");
      bus_wr(clm_addr(0), 32'd3);
      bus_wr(clm_addr(0), 32'd5);
      // Constrained random phase
      for (int n = 0; n < 3000; n++) begin
         int op = int'($urandom % 9);
         int c  = int'($urandom % NC);
         case (op)
            0, 1: set_src(int'($urandom % NS) + 1, 1'($urandom));
            2: bus_wr(4 * int'($urandom % (NS + 2)), $urandom);
            3: bus_wr(en_addr(c, 0), $urandom);
            4: bus_wr(thr_addr(c), 32'($urandom % 8));
            5: bus_rd(clm_addr(c), "R5 random claim");
            6: bus_wr(clm_addr(c), 32'($urandom % (NS + 3)));
            7: bus_rd(PEND_A, "R9 random pending");
            default: bus_rd(4 * int'($urandom % (NS + 1)), "R2 random prio");
         endcase
      end
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule